// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block changes the internal clock mode of an audio DSP between direct operation from a 512×fs master clock and operation from a 256×fs master clock that an on-chip doubler raises to 512×fs. The clock can glitch while the mode changes, so the block only flips its mode bit while the core is protected. One way is to stop the internal clock. The other is to shut the core down in an orderly way.

A request carries a target mode and a choice of procedure. On the power-down path, the sequencer stops the internal clock, writes the mode, and waits out the doubler settling time before it restarts the clock. On the halt path, it asks the core to ramp the volume down and stop. It writes the mode once the core reports that it has halted, or once a shutdown timeout expires, whichever comes first. It then releases the halt so the core restarts.

Both waits are counted in reference clock cycles from a clock-frequency parameter given in kHz. The settle wait is 1 ms and the shutdown timeout is 20 ms.

Top module: `clk_mode_switch_seq`

## Requirements
- R1: After reset, `modeSel` is 0, `pwrDown` is 0, `haltCore` is 0 and `busy` is 0. `modeSel` 0 means direct 512×fs operation and 1 means the doubled 256×fs input.
- R2: A request sampled while idle, with `reqMode` different from `modeSel` and `reqViaHalt` = 0, raises `pwrDown` and `busy` on the next cycle, while `modeSel` keeps its old value in that cycle.
- R3: `modeSel` changes only in a cycle that follows a cycle in which `pwrDown` or `haltCore` was high.
- R4: On the power-down path, `modeSel` takes the target one cycle after `pwrDown` rises. `pwrDown` then stays high for exactly CLK_KHZ × SETTLE_MS further cycles before it falls.
- R5: A request sampled while idle, with `reqMode` different from `modeSel` and `reqViaHalt` = 1, raises `haltCore` and `busy` on the next cycle without touching `pwrDown`.
- R6: On the halt path, if `coreHalted` is sampled high, `modeSel` takes the target on the next cycle and `haltCore` falls one cycle after that.
- R7: On the halt path, if `coreHalted` never rises, `modeSel` takes the target CLK_KHZ × SHUTDOWN_MS cycles after `haltCore` rises, and `haltCore` falls one cycle later.
- R8: A request sampled while `busy` is high is ignored. The running sequence keeps its timing and its target.
- R9: A request whose `reqMode` equals `modeSel` completes at once. `pwrDown`, `haltCore` and `busy` stay low.
- R10: `busy` is high exactly when `pwrDown` or `haltCore` is high.
- R11: `pwrDown` and `haltCore` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Mode change request strobe |
| reqMode | input | 1 | Target mode (0 direct 512×fs, 1 doubled 256×fs) |
| reqViaHalt | input | 1 | 1 selects the halt procedure, 0 the power-down procedure |
| coreHalted | input | 1 | Core reports that it has stopped |
| pwrDown | output | 1 | Stops the internal clock |
| haltCore | output | 1 | Requests ramp-down and core shutdown |
| modeSel | output | 1 | Clock mode control bit |
| busy | output | 1 | Sequence in progress |

## Verification
A corrupted sequencer state shows at the ports within one cycle. It appears as a mode bit that moves while neither protection output is high, a protection output that is missing or out of step with busy, or power-down and halt being high together. A wrong counter value appears only at the end of a wait, as a release that comes early or late by a number of cycles. The bench therefore compares every output on every clock against a behavioural model, so an error is caught in the first cycle it differs. A mishandled request while busy shows up as a wrong final mode or as changed timing of the release.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PD_WRITE  = 3'd1,
    ST_PD_SETTLE = 3'd2,
    ST_HALT_WAIT = 3'd3,
    ST_HALT_REL  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic loadTgt;
    logic setPd;
    logic clrPd;
    logic setHalt;
    logic clrHalt;
    logic applyMode;
    logic cntClr;
  } seqStrobe_t;

endpackage

// File: rtl/cms_datapath.sv
module cms_datapath
  import cms_pkg::*;
#(
  parameter int SETTLE_CYC = 1000,
  parameter int SHUT_CYC   = 20000,
  localparam int CNT_W     = $clog2(SHUT_CYC + 1) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  input  logic       reqMode,
  output logic       curMode,
  output logic       pwrDown,
  output logic       haltCore,
  output logic       settleEnd,
  output logic       shutEnd
);

  logic             tgtMode;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtMode  <= 1'b0;
      curMode  <= 1'b0;
      pwrDown  <= 1'b0;
      haltCore <= 1'b0;
    end else begin
      if (stb.loadTgt)   tgtMode  <= reqMode;
      if (stb.applyMode) curMode  <= tgtMode;
      if (stb.setPd)     pwrDown  <= 1'b1;
      else if (stb.clrPd) pwrDown <= 1'b0;
      if (stb.setHalt)   haltCore <= 1'b1;
      else if (stb.clrHalt) haltCore <= 1'b0;
    end
  end

  // Wait counter: cleared on entry to a wait, saturates at its top value
  always_ff @(posedge clk) begin
    if (!rstN || stb.cntClr) begin
      waitCnt <= '0;
    end else if (waitCnt != {CNT_W{1'b1}}) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign settleEnd = (waitCnt == CNT_W'(SETTLE_CYC - 1));
  assign shutEnd   = (waitCnt == CNT_W'(SHUT_CYC - 1));

endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqMode,
  input  logic       reqViaHalt,
  input  logic       coreHalted,
  input  logic       curMode,
  input  logic       settleEnd,
  input  logic       shutEnd,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && (reqMode != curMode)) begin
          stb.loadTgt = 1'b1;
          stb.cntClr  = 1'b1;
          if (reqViaHalt) begin
            stb.setHalt = 1'b1;
            nextState   = ST_HALT_WAIT;
          end else begin
            stb.setPd = 1'b1;
            nextState = ST_PD_WRITE;
          end
        end
      end
      ST_PD_WRITE: begin
        stb.applyMode = 1'b1;
        stb.cntClr    = 1'b1;
        nextState     = ST_PD_SETTLE;
      end
      ST_PD_SETTLE: begin
        if (settleEnd) begin
          stb.clrPd = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_HALT_WAIT: begin
        if (coreHalted || shutEnd) begin
          stb.applyMode = 1'b1;
          nextState     = ST_HALT_REL;
        end
      end
      ST_HALT_REL: begin
        stb.clrHalt = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/clk_mode_switch_seq.sv
module clk_mode_switch_seq
  import cms_pkg::*;
#(
  parameter int CLK_KHZ     = 24576,
  parameter int SETTLE_MS   = 1,
  parameter int SHUTDOWN_MS = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqMode,
  input  logic reqViaHalt,
  input  logic coreHalted,
  output logic pwrDown,
  output logic haltCore,
  output logic modeSel,
  output logic busy
);

  localparam int SETTLE_CYC = CLK_KHZ * SETTLE_MS;
  localparam int SHUT_CYC   = CLK_KHZ * SHUTDOWN_MS;

  seqStrobe_t stb;
  logic       settleEnd;
  logic       shutEnd;

  cms_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqMode    (reqMode),
    .reqViaHalt (reqViaHalt),
    .coreHalted (coreHalted),
    .curMode    (modeSel),
    .settleEnd  (settleEnd),
    .shutEnd    (shutEnd),
    .stb        (stb),
    .busy       (busy)
  );

  cms_datapath #(
    .SETTLE_CYC (SETTLE_CYC),
    .SHUT_CYC   (SHUT_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqMode   (reqMode),
    .curMode   (modeSel),
    .pwrDown   (pwrDown),
    .haltCore  (haltCore),
    .settleEnd (settleEnd),
    .shutEnd   (shutEnd)
  );

endmodule

// File: rtl/cms_checker.sv
module cms_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqMode,
  input logic reqViaHalt,
  input logic pwrDown,
  input logic haltCore,
  input logic modeSel,
  input logic busy
);

  // R3
  mode_guarded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel)) |-> ($past(pwrDown) || $past(haltCore)));

  // R10
  busy_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy == (pwrDown || haltCore));

  // R11
  excl_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pwrDown && haltCore));

  // R9
  same_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (reqMode == modeSel)) |=> !busy);

  // R2
  pd_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (reqMode != modeSel) && !reqViaHalt)
      |=> (pwrDown && !haltCore && $stable(modeSel)));

  // R5
  halt_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (reqMode != modeSel) && reqViaHalt)
      |=> (haltCore && !pwrDown && $stable(modeSel)));

endmodule

bind clk_mode_switch_seq cms_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqMode    (reqMode),
  .reqViaHalt (reqViaHalt),
  .pwrDown    (pwrDown),
  .haltCore   (haltCore),
  .modeSel    (modeSel),
  .busy       (busy)
);

// File: tb/sim_clk_mode_switch_seq.sv
module sim_clk_mode_switch_seq;

  localparam int KHZ  = 10;
  localparam int SET  = KHZ * 1;
  localparam int SHUT = KHZ * 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqMode = 1'b0, reqViaHalt = 1'b0, coreHalted = 1'b0;
  logic pwrDown, haltCore, modeSel, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  clk_mode_switch_seq #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqViaHalt(reqViaHalt), .coreHalted(coreHalted),
    .pwrDown(pwrDown), .haltCore(haltCore), .modeSel(modeSel), .busy(busy)
  );

  // Behavioural reference model
  int ph = 0;
  int cnt = 0;
  bit mPd = 0, mHalt = 0, mMode = 0, mTgt = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      ph = 0; cnt = 0; mPd = 0; mHalt = 0; mMode = 0; mTgt = 0;
    end else begin
      case (ph)
        0: if (reqValid && reqMode != mMode) begin
             mTgt = reqMode; cnt = 0;
             if (reqViaHalt) begin mHalt = 1; ph = 3; end
             else begin mPd = 1; ph = 1; end
           end
        1: begin mMode = mTgt; cnt = 0; ph = 2; end
        2: if (cnt == SET - 1) begin mPd = 0; ph = 0; end else cnt++;
        3: if (coreHalted || cnt == SHUT - 1) begin mMode = mTgt; ph = 4; end
           else cnt++;
        default: begin mHalt = 0; ph = 0; end
      endcase
    end
  end

  task automatic cmp(string t, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", t, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp(tag, "pwrDown", pwrDown, mPd);
      cmp(tag, "haltCore", haltCore, mHalt);
      cmp(tag, "modeSel", modeSel, mMode);
      cmp(tag, "busy", busy, ph != 0);
      cmp("R10", "busy vs protect", busy, pwrDown | haltCore);
      cmp("R11", "exclusive", pwrDown & haltCore, 1'b0);
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic request(bit m, bit viaHalt);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqViaHalt = viaHalt;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rstN = 1'b1;
    idle(2);

    // Power-down path 0 -> 1
    tag = "R2"; request(1'b1, 1'b0);
    tag = "R4"; idle(SET + 4);
    cmp("R4", "final mode", modeSel, 1'b1);

    // Same mode request: nothing toggles
    tag = "R9"; request(1'b1, 1'b0);
    cmp("R9", "busy after same-mode", busy, 1'b0);
    idle(3);

    // Halt path 1 -> 0 with halted status after some cycles
    tag = "R5"; request(1'b0, 1'b1);
    tag = "R6"; idle(25);
    coreHalted = 1'b1;
    idle(4);
    coreHalted = 1'b0;
    cmp("R6", "final mode", modeSel, 1'b0);
    idle(3);

    // Halt path 0 -> 1 with timeout, plus a request while busy
    tag = "R7"; request(1'b1, 1'b1);
    idle(5);
    tag = "R8"; request(1'b0, 1'b0);
    tag = "R7"; idle(SHUT + 5);
    cmp("R7", "final mode", modeSel, 1'b1);

    // Power-down path 1 -> 0, busy request mid-settle
    tag = "R3"; request(1'b0, 1'b0);
    idle(3);
    tag = "R8"; request(1'b1, 1'b1);
    tag = "R4"; idle(SET + 4);
    cmp("R8", "final mode", modeSel, 1'b0);

    // Reset in mid-sequence returns to defaults
    request(1'b1, 1'b0);
    idle(2);
    tag = "R1"; rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule